// File: doc/BRIEF.md
# Hybrid Port Scheduler

This block shares one router datapath among five input ports (north, east, south, west and local). Every port owns a small FIFO of 32-bit spike packets. A port is pending while its FIFO holds at least one packet. Each cycle in which the downstream side is ready, the scheduler picks at most one pending port. It pops that port's oldest packet and hands it downstream, together with a one-hot grant and the port number.

The choice between ports depends on the load. While some ports are idle, the scheduler serves the port that became pending earliest. It keeps that order in a short queue of port numbers, so idle ports cost no cycles. When every port is pending, it rotates a round-robin pointer instead, so the port served last has the lowest priority. A port that still holds packets after a grant rejoins the back of the arrival queue. Ports that become pending in the same cycle are ordered by rotation, starting after the port granted last. A write into a full FIFO is discarded and flagged in the same cycle.

Top module: `hybrid_port_scheduler`

## Requirements
- R1: After reset, and after any reset in mid-run, `grant`, `out_valid` and `drop` are zero, all FIFOs are empty, and the rotation pointer starts so that port 0 ranks first.
- R2: `grant` is zero or one-hot. It is nonzero only in a cycle where `out_ready` is high and some port is pending. `out_valid` is high exactly when `grant` is nonzero.
- R3: Only a pending port is granted. A packet written in cycle c can be granted no earlier than cycle c+1.
- R4: While not every port is pending, the grant goes to the port that became pending earliest (first come, first served).
- R5: Ports that become pending in the same cycle are queued in rotating order, starting with the port after the one granted last.
- R6: While all ports are pending and `out_ready` is high, the grant goes to the first port after the port granted last, wrapping from 4 to 0.
- R7: A granted port that still holds packets goes to the back of the arrival queue.
- R8: In the cycle of a grant, `out_data` is the oldest packet of the granted port. Each port delivers its packets in write order.
- R9: A write to a full FIFO is discarded, and `drop` bit p is high in that same cycle. The FIFO contents stay unchanged.
- R10: Port p drives `in_valid[p]` and `in_data[32p+31:32p]`, and it is granted on `grant[p]` with `out_port` = p. The port numbers are 0 north, 1 east, 2 south, 3 west and 4 local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-port write strobe into the port FIFO |
| in_data | input | 160 | Per-port 32-bit packet, port p in bits 32p+31:32p |
| out_ready | input | 1 | Downstream can accept a packet this cycle |
| grant | output | 5 | One-hot grant; it also pops the granted FIFO |
| out_valid | output | 1 | A packet is presented this cycle |
| out_data | output | 32 | Packet of the granted port |
| out_port | output | 3 | Number of the granted port |
| drop | output | 5 | Per-port pulse when a write hit a full FIFO |

## Verification
A write at one rising edge makes its port pending from that edge on. `grant`, `out_valid`, `out_data` and `out_port` are combinational from that state and from the current `out_ready`, so a packet can be granted one cycle after the cycle that wrote it. The pop takes effect at the edge that closes the grant cycle. `drop` depends only on the current write and the FIFO fill level, so it is due in the cycle of the write itself. The bench drives inputs just after the falling edge and samples one time unit later, before the next rising edge. Expected grants come from a per-cycle table worked out by hand from these rules, and expected packets come from per-port write and read counters.

// File: rtl/hps_pkg.sv
package hps_pkg;
   typedef enum logic [2:0] {
      PORT_NORTH = 3'd0,
      PORT_EAST  = 3'd1,
      PORT_SOUTH = 3'd2,
      PORT_WEST  = 3'd3,
      PORT_LOCAL = 3'd4
   } port_id_e;

   localparam int unsigned MAX_FIFO_DEPTH = 5;
endpackage

// File: rtl/hps_port_fifo.sv
module hps_port_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         nonempty_next,
   output logic         drop
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q, cnt_d;
   logic          full, wr_ok, rd_ok;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign wr_ok = wr_en & ~full;
   assign rd_ok = rd_en & ~empty;
   assign drop  = wr_en & full;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_ok && !rd_ok) cnt_d = cnt_q + CW'(1);
      else if (rd_ok && !wr_ok) cnt_d = cnt_q - CW'(1);
   end
   assign nonempty_next = (cnt_d != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     hold_q <= '0;
            else if (wr_ok) hold_q <= wr_data;
         end
         assign rd_data = hold_q;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [W-1:0]  mem_q [DEPTH];
         logic [AW-1:0] wp_q, rp_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q <= '0;
               rp_q <= '0;
            end else begin
               if (wr_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
               if (rd_ok) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            end
         end

         always_ff @(posedge clk) begin
            if (wr_ok) mem_q[wp_q] <= wr_data;
         end
         assign rd_data = mem_q[rp_q];
      end
   endgenerate
endmodule

// File: rtl/hps_arrival_queue.sv
module hps_arrival_queue #(
   parameter int NP   = 5,
   parameter int IDXW = $clog2(NP),
   parameter int CW   = $clog2(NP + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rm_en,
   input  logic [IDXW-1:0] rm_idx,
   input  logic [NP-1:0]   push_mask,
   input  logic [IDXW-1:0] last_idx,
   output logic [IDXW-1:0] head_idx,
   output logic            head_vld,
   output logic [CW-1:0]   occ
);
   logic [IDXW-1:0] slot_q [NP];
   logic [IDXW-1:0] slot_d [NP];
   logic [CW-1:0]   cnt_q, cnt_d;
   logic [IDXW-1:0] p;

   function automatic logic [IDXW-1:0] rot(input logic [IDXW-1:0] base, input int k);
      int s;
      s = int'(base) + k;
      if (s >= NP) s = s - NP;
      return IDXW'(s);
   endfunction

   always_comb begin
      cnt_d = '0;
      p     = '0;
      for (int i = 0; i < NP; i++) slot_d[i] = '0;
      // keep survivors in order, dropping the granted entry
      for (int i = 0; i < NP; i++) begin
         if (CW'(i) < cnt_q && !(rm_en && slot_q[i] == rm_idx)) begin
            slot_d[cnt_d] = slot_q[i];
            cnt_d = cnt_d + CW'(1);
         end
      end
      // append newcomers in rotating order after the last grant
      for (int k = 1; k <= NP; k++) begin
         p = rot(last_idx, k);
         if (push_mask[p] && cnt_d < CW'(NP)) begin
            slot_d[cnt_d] = p;
            cnt_d = cnt_d + CW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < NP; i++) slot_q[i] <= '0;
      end else begin
         cnt_q <= cnt_d;
         for (int i = 0; i < NP; i++) slot_q[i] <= slot_d[i];
      end
   end

   assign head_idx = slot_q[0];
   assign head_vld = (cnt_q != '0);
   assign occ      = cnt_q;
endmodule

// File: rtl/hps_grant_pick.sv
module hps_grant_pick #(
   parameter int NP   = 5,
   parameter int IDXW = $clog2(NP)
) (
   input  logic [NP-1:0]   pend,
   input  logic [IDXW-1:0] head_idx,
   input  logic            head_vld,
   input  logic [IDXW-1:0] last_idx,
   input  logic            ready,
   output logic [NP-1:0]   grant,
   output logic [IDXW-1:0] gidx,
   output logic            gvld
);
   logic [IDXW-1:0] p;

   function automatic logic [IDXW-1:0] rot(input logic [IDXW-1:0] base, input int k);
      int s;
      s = int'(base) + k;
      if (s >= NP) s = s - NP;
      return IDXW'(s);
   endfunction

   always_comb begin
      gidx = '0;
      gvld = 1'b0;
      p    = '0;
      if (ready && (|pend)) begin
         if (&pend) begin
            for (int k = 1; k <= NP; k++) begin
               p = rot(last_idx, k);
               if (!gvld && pend[p]) begin
                  gidx = p;
                  gvld = 1'b1;
               end
            end
         end else if (head_vld) begin
            gidx = head_idx;
            gvld = 1'b1;
         end
      end
   end

   assign grant = gvld ? (NP'(1) << gidx) : '0;
endmodule

// File: rtl/hybrid_port_scheduler.sv
module hybrid_port_scheduler #(
   parameter int NP    = 5,
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NP-1:0]         in_valid,
   input  logic [NP*W-1:0]       in_data,
   input  logic                  out_ready,
   output logic [NP-1:0]         grant,
   output logic                  out_valid,
   output logic [W-1:0]          out_data,
   output logic [$clog2(NP)-1:0] out_port,
   output logic [NP-1:0]         drop
);
   import hps_pkg::*;

   localparam int IDXW = $clog2(NP);
   localparam int CW   = $clog2(NP + 1);

   generate
      if (NP < 2) begin : g_bad_np
         $error("hybrid_port_scheduler: NP must be at least 2");
      end
      if (DEPTH < 1 || DEPTH > int'(MAX_FIFO_DEPTH)) begin : g_bad_depth
         $error("hybrid_port_scheduler: DEPTH out of range");
      end
      if (W < 1) begin : g_bad_w
         $error("hybrid_port_scheduler: W must be positive");
      end
   endgenerate

   logic [NP-1:0]   empty, nz_next, pend, push_mask;
   logic [W-1:0]    head_data [NP];
   logic [IDXW-1:0] last_q, gidx, q_head;
   logic            gvld, q_vld;
   logic [CW-1:0]   q_cnt;

   genvar gp;
   generate
      for (gp = 0; gp < NP; gp++) begin : g_port
         hps_port_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (in_valid[gp]),
            .wr_data      (in_data[gp*W +: W]),
            .rd_en        (grant[gp]),
            .rd_data      (head_data[gp]),
            .empty        (empty[gp]),
            .nonempty_next(nz_next[gp]),
            .drop         (drop[gp])
         );
         assign pend[gp]      = ~empty[gp];
         assign push_mask[gp] = nz_next[gp] & (empty[gp] | grant[gp]);
      end
   endgenerate

   hps_arrival_queue #(.NP(NP), .IDXW(IDXW), .CW(CW)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .rm_en    (gvld),
      .rm_idx   (gidx),
      .push_mask(push_mask),
      .last_idx (last_q),
      .head_idx (q_head),
      .head_vld (q_vld),
      .occ      (q_cnt)
   );

   hps_grant_pick #(.NP(NP), .IDXW(IDXW)) u_pick (
      .pend    (pend),
      .head_idx(q_head),
      .head_vld(q_vld),
      .last_idx(last_q),
      .ready   (out_ready),
      .grant   (grant),
      .gidx    (gidx),
      .gvld    (gvld)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    last_q <= IDXW'(NP - 1);
      else if (gvld) last_q <= gidx;
   end

   always_comb begin
      out_data = '0;
      for (int i = 0; i < NP; i++) begin
         if (gvld && gidx == IDXW'(i)) out_data = head_data[i];
      end
   end

   assign out_valid = gvld;
   assign out_port  = gvld ? gidx : '0;
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
   parameter int NP = 5,
   parameter int CW = $clog2(NP + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_ready,
   input logic [NP-1:0] grant,
   input logic          out_valid,
   input logic [NP-1:0] pend,
   input logic [NP-1:0] in_valid,
   input logic [NP-1:0] drop,
   input logic [CW-1:0] q_cnt
);
   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R2
   grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> grant == '0);
   // R2
   valid_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (grant != '0));
   // R3
   grant_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~pend) == '0);
   // R6
   busy_always_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((&pend) && out_ready) |-> out_valid);
   // R7
   queue_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_cnt) == $countones(pend));
   // R9
   drop_only_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop & ~(in_valid & pend)) == '0);
endmodule

bind hybrid_port_scheduler hps_checker #(.NP(NP), .CW($clog2(NP + 1))) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_ready(out_ready),
   .grant    (grant),
   .out_valid(out_valid),
   .pend     (pend),
   .in_valid (in_valid),
   .drop     (drop),
   .q_cnt    (q_cnt)
);

// File: tb/hybrid_port_scheduler_tb.sv
`timescale 1ns/1ps
module hybrid_port_scheduler_tb;
   localparam int NP = 5;
   localparam int W = 32;
   localparam int DEPTH = 4;
   localparam int NROWS = 39;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   in_valid = '0;
   logic [NP*W-1:0] in_data = '0;
   logic            out_ready = 1'b0;
   logic [NP-1:0]   grant;
   logic            out_valid;
   logic [W-1:0]    out_data;
   logic [2:0]      out_port;
   logic [NP-1:0]   drop;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int wr_ser [NP];
   int rd_ser [NP];

   always #5 clk = ~clk;

   hybrid_port_scheduler #(.NP(NP), .W(W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_ready(out_ready), .grant(grant), .out_valid(out_valid),
      .out_data(out_data), .out_port(out_port), .drop(drop)
   );

   // row = {write mask[4:0], out_ready, expected grant[4:0]}
   localparam logic [10:0] VEC [NROWS] = '{
      11'b00100_1_00000, // R3 write port 2, nothing pending yet
      11'b00000_1_00100, // R3 R10 granted one cycle later
      11'b00000_1_00000,
      11'b01000_0_00000, // R4 arrivals 3, then 1, then 0
      11'b00010_0_00000,
      11'b00001_0_00000,
      11'b00000_0_00000, // R2 held while not ready
      11'b00000_1_01000, // R4 first come
      11'b00000_1_00010,
      11'b00000_1_00001,
      11'b00000_1_00000,
      11'b01001_0_00000, // R5 ports 0 and 3 together, last grant 0
      11'b00000_1_01000, // R5 rotation starts at 1, so 3 first
      11'b00000_1_00001,
      11'b00000_1_00000,
      11'b10000_0_00000, // R6 arrivals 4,3,2,1,0
      11'b01000_0_00000,
      11'b00100_0_00000,
      11'b00010_0_00000,
      11'b00001_0_00000,
      11'b11111_0_00000, // second packet everywhere
      11'b00000_1_00010, // R6 all busy: rotate after 0
      11'b00000_1_00100,
      11'b00000_1_01000,
      11'b00000_1_10000,
      11'b00000_1_00001,
      11'b00000_1_00010,
      11'b00000_1_00100,
      11'b00000_1_01000,
      11'b00000_1_10000,
      11'b00000_1_00001,
      11'b00000_1_00000,
      11'b00010_0_00000, // R7 port 1 twice, then port 3
      11'b00010_0_00000,
      11'b01000_0_00000,
      11'b00000_1_00010,
      11'b00000_1_01000, // R7 port 1 rejoined behind 3
      11'b00000_1_00010,
      11'b00000_1_00000
   };

   function automatic logic [W-1:0] mk(input int p, input int k);
      return 32'h5A00_0000 | (32'(p) << 8) | 32'(k & 8'hFF);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [NP-1:0] wr, input logic rdy);
      @(negedge clk);
      in_valid = wr;
      out_ready = rdy;
      for (int p = 0; p < NP; p++) in_data[p*W +: W] = mk(p, wr_ser[p]);
      #1;
   endtask

   // checks one granted port and its packet against the bench counters
   task automatic expect_grant(input logic [NP-1:0] exp, input string tag);
      int gp;
      gp = 0;
      check(grant == exp && out_valid == (exp != '0), tag, 32'(grant), 32'(exp));
      if (exp != '0) begin
         for (int p = 0; p < NP; p++) if (exp[p]) gp = p;
         check(out_data == mk(gp, rd_ser[gp]), {tag, " R8 data"}, out_data, mk(gp, rd_ser[gp]));
         check(out_port == 3'(gp), {tag, " R10 port"}, 32'(out_port), 32'(gp));
         rd_ser[gp]++;
      end
   endtask

   task automatic commit_writes(input logic [NP-1:0] wr);
      for (int p = 0; p < NP; p++) if (wr[p]) wr_ser[p]++;
   endtask

   initial begin
      for (int p = 0; p < NP; p++) begin
         wr_ser[p] = 0;
         rd_ser[p] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(grant == '0 && !out_valid && drop == '0, "R1 reset state", 32'(grant), 32'h0);

      for (int r = 0; r < NROWS; r++) begin
         drive(VEC[r][10:6], VEC[r][5]);
         expect_grant(VEC[r][4:0], "R2/R4/R5/R6/R7 table");
         check(drop == '0, "R9 no drop in table", 32'(drop), 32'h0);
         commit_writes(VEC[r][10:6]);
      end

      // R9 fill port 2, then overfill
      for (int i = 0; i < DEPTH; i++) begin
         drive(5'b00100, 1'b0);
         check(drop == '0, "R9 drop while filling", 32'(drop), 32'h0);
         commit_writes(5'b00100);
      end
      drive(5'b00100, 1'b0);
      check(drop == 5'b00100, "R9 drop on full", 32'(drop), 32'h4);
      drive(5'b00000, 1'b0);
      check(drop == '0, "R9 drop is a pulse", 32'(drop), 32'h0);
      for (int i = 0; i < DEPTH; i++) begin
         drive(5'b00000, 1'b1);
         expect_grant(5'b00100, "R9 drain after drop");
      end
      drive(5'b00000, 1'b1);
      expect_grant(5'b00000, "R9 dropped packet not stored");

      // R1 reset in mid-run with packets pending
      drive(5'b10001, 1'b0);
      commit_writes(5'b10001);
      @(negedge clk);
      in_valid = '0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_ser[0] = wr_ser[0];
      rd_ser[4] = wr_ser[4];
      drive(5'b00000, 1'b1);
      expect_grant(5'b00000, "R1 FIFOs empty after reset");
      // R1 R5 rotation restarts at port 0: ports 3 and 1 together give 1 first
      drive(5'b01010, 1'b0);
      commit_writes(5'b01010);
      drive(5'b00000, 1'b1);
      expect_grant(5'b00010, "R1 R5 pointer after reset");
      drive(5'b00000, 1'b1);
      expect_grant(5'b01000, "R1 R5 second of tie");
      drive(5'b00000, 1'b1);
      expect_grant(5'b00000, "R3 idle after drain");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule